// File: doc/BRIEF.md
# Dual-channel audio sample FIFO with interrupts

This block buffers audio samples for two channels, A and B. Each channel has a byte-wide queue, 1024 entries deep by default. A host writes samples through a valid/ready push port. A consumer running at the output sample rate pulses `tick`. On each tick, every channel that holds data gives up its oldest byte. A channel that is empty presents the unsigned midpoint 0x80, which means silence, and is not popped.

Each channel keeps two status bits: half-full (bit 0) and full/empty (bit 1). When certain counts are reached, the channel raises a shared interrupt line. A small register interface sets the operating mode and the per-channel half-full interrupt enables. It can also flush both queues. Reading the status register returns both channels packed together. The same read clears the status and lowers the interrupt.

The queue behaviour applies only in queue mode (mode 1). In any other mode a push stores its byte directly at the given address of the selected channel's buffer. A debug peek port reads any buffer location combinationally.

Push port back-pressure works as follows:
- A push is taken on a rising clock edge while `push_valid` and `push_ready` are both high.
- `push_ready` is low only in queue mode, when the selected channel holds 1024 bytes.
- The consumer side has no back-pressure. `samp_out` is valid in every cycle, and `tick` pops unconditionally from channels that are not empty.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset the mode register (address 0x1) reads 0, the half-full enable register (address 0x4, bit 0 = A, bit 1 = B) reads 2'b11, the status register reads 0, `irq` is low and both sample outputs are 0x80.
- R2: In queue mode, bytes leave each channel in the order they were pushed. The channel accepts 1024 bytes before it is full, and its buffer positions wrap back to the start after the last entry.
- R3: A tick on an empty channel presents 0x80 for that channel and leaves its count and status unchanged.
- R4: After any accepted push or pop, the half-full bit (bit 0) of that channel is 1 when the resulting count is 511 or less, and 0 otherwise.
- R5: With the channel's enable bit set, `irq` rises when a push alone brings the count to exactly 512, or when a pop alone brings it to exactly 511. With the enable bit clear, neither event raises `irq`.
- R6: A push alone that brings the count to 1023, or a pop alone that brings it to 0, sets the full/empty bit (bit 1) and raises `irq`.
- R7: A read of the status register (address 0x3) returns channel A status in bits 1:0 and channel B status in bits 3:2. The read then clears both fields and lowers `irq`, unless a new event occurs in the same cycle.
- R8: Both queues are flushed (count, positions and status to 0, `irq` low) by a write to the control register (address 0x2) with bit 7 set, or by a write to the mode register whose bits 1:0 differ from the current mode. A write of the same mode value, or a control write with bit 7 clear, changes nothing. The mode register keeps only bits 1:0 of the written value.
- R9: Outside queue mode a push stores `push_data` at `push_addr` of the selected channel and does not queue it. `push_ready` stays high, and the peek port returns the stored byte.
- R10: In queue mode `push_ready` is low while the selected channel holds 1024 bytes. A push offered then is not taken.
- R11: A push and a pop on one channel in the same cycle leave its count unchanged and raise no half-full or full/empty interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect on status) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| push_valid | input | 1 | Push request valid |
| push_ready | output | 1 | Push can be taken |
| push_ch | input | 1 | Push channel select (0 = A, 1 = B) |
| push_addr | input | 10 | Direct-store address (used outside queue mode) |
| push_data | input | 8 | Push byte |
| tick | input | 1 | Sample-rate pop strobe for all channels |
| samp_out | output | 16 | Current sample, A in bits 7:0, B in bits 15:8 |
| peek_ch | input | 1 | Peek channel select |
| peek_addr | input | 10 | Peek buffer address |
| peek_data | output | 8 | Peeked byte |
| irq | output | 1 | Shared interrupt, level high |

## Verification
The hardest corners to reach are at the top of the queue: the full/empty event at 1023, the refused push at 1024, and pointer wrap after a complete drain. The stimulus reaches them by pushing a numbered byte stream of exactly 1023 and then 1024 bytes, offering one extra push, and then draining while the order of every byte is checked. The bench also parks a channel at exactly 512 and applies a push and a tick together. A following lone pop then shows that the count stayed at 512, because that pop raises the 511 half-full interrupt.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_MODE = 4'h1,
    RA_CTRL = 4'h2,
    RA_STAT = 4'h3,
    RA_HIEN = 4'h4
  } reg_addr_e;

  localparam logic [1:0] MODE_QUEUE     = 2'd1;
  localparam int         CTRL_FLUSH_BIT = 7;

  // bit 1 = full/empty event, bit 0 = half-full level
  typedef struct packed {
    logic fe;
    logic half;
  } ch_stat_t;
endpackage

// File: rtl/snd_fifo_regs.sv
module snd_fifo_regs
  import snd_fifo_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_AW-1:0]     addr,
  input  logic [REG_DW-1:0]     wdata,
  input  logic [2*NUM_CH-1:0]   stat_flat,
  output logic [REG_DW-1:0]     rdata,
  output logic [1:0]            mode_q,
  output logic [NUM_CH-1:0]     hien_q,
  output logic                  flush,
  output logic                  stat_clr
);
  logic mode_wr, ctrl_wr, hien_wr;
  logic unused_bits;

  assign mode_wr  = wr_en && (addr == RA_MODE);
  assign ctrl_wr  = wr_en && (addr == RA_CTRL);
  assign hien_wr  = wr_en && (addr == RA_HIEN);
  assign stat_clr = rd_en && (addr == RA_STAT);
  assign flush    = (mode_wr && (wdata[1:0] != mode_q)) ||
                    (ctrl_wr && wdata[CTRL_FLUSH_BIT]);
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      hien_q <= '1;
    end else begin
      if (mode_wr) mode_q <= wdata[1:0];
      if (hien_wr) hien_q <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    case (addr)
      RA_MODE: rdata = REG_DW'(mode_q);
      RA_STAT: rdata = REG_DW'(stat_flat);
      RA_HIEN: rdata = REG_DW'(hien_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/snd_fifo_chan.sv
module snd_fifo_chan
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       stat_clr,
  input  logic                       queue_mode,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic                       pop_req,
  input  logic                       half_ien,
  input  logic [$clog2(DEPTH)-1:0]   peek_addr,
  output logic [DW-1:0]              peek_data,
  output logic [DW-1:0]              samp,
  output logic [$clog2(DEPTH):0]     cnt,
  output logic                       full,
  output ch_stat_t                   stat,
  output logic                       evt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam logic [DW-1:0] SILENCE = DW'(1) << (DW - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          do_push, do_pop, only_push, only_pop;
  logic          half_evt, fe_evt;
  ch_stat_t      stat_q, stat_nxt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CW'(DEPTH));
  assign do_push   = queue_mode && wr_en && !full;
  assign do_pop    = pop_req && (cnt_q != '0);
  assign only_push = do_push && !do_pop;
  assign only_pop  = do_pop && !do_push;
  assign cnt_nxt   = cnt_q + CW'(do_push) - CW'(do_pop);

  assign half_evt = half_ien &&
                    ((only_push && (cnt_nxt == CW'(HALF))) ||
                     (only_pop  && (cnt_nxt == CW'(HALF - 1))));
  assign fe_evt   = (only_push && (cnt_nxt == CW'(DEPTH - 1))) ||
                    (only_pop  && (cnt_nxt == '0));
  assign evt      = (half_evt || fe_evt) && !flush;

  always_comb begin
    stat_nxt = stat_clr ? '0 : stat_q;
    if (do_push || do_pop) stat_nxt.half = (cnt_nxt <= CW'(HALF - 1));
    if (fe_evt)            stat_nxt.fe   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      cnt_q  <= cnt_nxt;
      stat_q <= stat_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)                  mem[wptr]    <= wr_data;
    else if (!queue_mode && wr_en) mem[wr_addr] <= wr_data;
  end

  assign samp      = (cnt_q != '0) ? mem[rptr] : SILENCE;
  assign peek_data = mem[peek_addr];
  assign cnt       = cnt_q;
  assign stat      = stat_q;
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DW     = 8,
  parameter int NUM_CH = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  input  logic                 push_valid,
  output logic                 push_ready,
  input  logic [CHW-1:0]       push_ch,
  input  logic [AW-1:0]        push_addr,
  input  logic [DW-1:0]        push_data,
  input  logic                 tick,
  output logic [NUM_CH*DW-1:0] samp_out,
  input  logic [CHW-1:0]       peek_ch,
  input  logic [AW-1:0]        peek_addr,
  output logic [DW-1:0]        peek_data,
  output logic                 irq
);
  localparam int CW = AW + 1;

  logic [1:0]          mode_q;
  logic [NUM_CH-1:0]   hien_q, full_vec, evt_vec;
  logic [2*NUM_CH-1:0] stat_flat;
  logic                flush, stat_clr, queue_mode, irq_q;
  logic [CW-1:0]       cnt_q    [NUM_CH];
  logic [DW-1:0]       peek_arr [NUM_CH];

  assign queue_mode = (mode_q == MODE_QUEUE);

  snd_fifo_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .stat_flat (stat_flat),
    .rdata     (reg_rdata),
    .mode_q    (mode_q),
    .hien_q    (hien_q),
    .flush     (flush),
    .stat_clr  (stat_clr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_stat_t st;
    snd_fifo_chan #(.DEPTH(DEPTH), .DW(DW)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .stat_clr   (stat_clr),
      .queue_mode (queue_mode),
      .wr_en      (push_valid && (push_ch == CHW'(g))),
      .wr_addr    (push_addr),
      .wr_data    (push_data),
      .pop_req    (tick),
      .half_ien   (hien_q[g]),
      .peek_addr  (peek_addr),
      .peek_data  (peek_arr[g]),
      .samp       (samp_out[g*DW +: DW]),
      .cnt        (cnt_q[g]),
      .full       (full_vec[g]),
      .stat       (st),
      .evt        (evt_vec[g])
    );
    assign stat_flat[2*g +: 2] = st;
  end

  assign push_ready = !queue_mode || !full_vec[push_ch];
  assign peek_data  = peek_arr[peek_ch];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) irq_q <= 1'b0;
    else if (|evt_vec)   irq_q <= 1'b1;
    else if (stat_clr)   irq_q <= 1'b0;
  end
  assign irq = irq_q;
endmodule

// File: rtl/snd_fifo_pair_chk.sv
module snd_fifo_pair_chk
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic              flush_bit,
  input logic              push_valid,
  input logic              tick,
  input logic              irq,
  input logic [1:0]        mode,
  input logic [CW-1:0]     cnt_a,
  input logic [CW-1:0]     cnt_b
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a == $past(cnt_a)) || (cnt_a == $past(cnt_a) + 1'b1) ||
    (cnt_a + 1'b1 == $past(cnt_a)) || (cnt_a == '0)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= CW'(DEPTH)) && (cnt_b <= CW'(DEPTH))); // R10

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !push_valid && (cnt_a == '0) |=> (cnt_a == '0)); // R3

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && (reg_addr == RA_STAT) && !push_valid && !tick |=> !irq); // R7

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && (reg_addr == RA_CTRL) && flush_bit
    |=> !irq && (cnt_a == '0) && (cnt_b == '0)); // R8

  AST_QUEUE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_QUEUE) |-> (cnt_a == '0) && (cnt_b == '0)); // R9
endmodule

bind snd_fifo_pair snd_fifo_pair_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_addr   (reg_addr),
  .flush_bit  (reg_wdata[7]),
  .push_valid (push_valid),
  .tick       (tick),
  .irq        (irq),
  .mode       (mode_q),
  .cnt_a      (cnt_q[0]),
  .cnt_b      (cnt_q[1])
);

// File: tb/snd_fifo_pair_tb_top.sv
module snd_fifo_pair_tb_top;
  import snd_fifo_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic        push_valid = 0, push_ready;
  logic        push_ch = 0, peek_ch = 0;
  logic [9:0]  push_addr = 0, peek_addr = 0;
  logic [7:0]  push_data = 0, peek_data;
  logic        tick = 0;
  logic [15:0] samp_out;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .push_valid(push_valid), .push_ready(push_ready), .push_ch(push_ch),
    .push_addr(push_addr), .push_data(push_data), .tick(tick),
    .samp_out(samp_out), .peek_ch(peek_ch), .peek_addr(peek_addr),
    .peek_data(peek_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all drive tasks start and end at a falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0; #1;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    reg_rd_en = 1; reg_addr = a; #1; d = reg_rdata;
    @(negedge clk); reg_rd_en = 0; #1;
  endtask

  task automatic push(input logic ch, input logic [7:0] d);
    push_valid = 1; push_ch = ch; push_data = d;
    @(negedge clk); push_valid = 0; #1;
  endtask

  task automatic push_at(input logic ch, input logic [9:0] a, input logic [7:0] d);
    push_addr = a; push(ch, d); push_addr = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0; #1;
  endtask

  task automatic flush_all();
    wr_reg(RA_CTRL, 8'h80);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(RA_MODE, d); chk("R1 mode", d, 0);
    rd_reg(RA_HIEN, d); chk("R1 hien", d, 8'h03);
    rd_reg(RA_STAT, d); chk("R1 stat", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 samp", samp_out, 16'h8080);
  endtask

  task automatic t_direct();
    push_at(0, 10'd5, 8'h3C);
    push_at(1, 10'd7, 8'h5A);
    peek_ch = 0; peek_addr = 5; #1; chk("R9 peek A", peek_data, 8'h3C);
    peek_ch = 1; peek_addr = 7; #1; chk("R9 peek B", peek_data, 8'h5A);
    push_ch = 0; #1; chk("R9 ready", push_ready, 1);
    chk("R9 not queued", samp_out, 16'h8080);
  endtask

  task automatic t_order();
    logic [7:0] d;
    wr_reg(RA_MODE, 8'h01);
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33); push(1, 8'h44);
    chk("R5 no irq low count", irq, 0);
    rd_reg(RA_STAT, d); chk("R7 packed half bits", d, 8'h05);
    rd_reg(RA_STAT, d); chk("R7 cleared", d, 8'h00);
    chk("R2 heads", samp_out, 16'h4411);
    pulse_tick();
    chk("R3 B silent, R2 A next", samp_out, 16'h8022);
    chk("R6 empty irq", irq, 1);
    rd_reg(RA_STAT, d); chk("R6 R7 stat", d, 8'h0D);
    chk("R7 irq lowered", irq, 0);
    pulse_tick(); chk("R2 third", samp_out[7:0], 8'h33);
    pulse_tick(); chk("R6 A empty irq", irq, 1);
    rd_reg(RA_STAT, d); chk("R6 A stat", d, 8'h03);
    pulse_tick();
    chk("R3 silence", samp_out, 16'h8080);
    rd_reg(RA_STAT, d); chk("R3 status unchanged", d, 8'h00);
    chk("R3 no irq", irq, 0);
  endtask

  task automatic t_half();
    logic [7:0] d;
    flush_all();
    for (int i = 0; i < 511; i++) push(0, 8'(i));
    chk("R5 no irq at 511 push", irq, 0);
    push(0, 8'hFF);
    chk("R5 irq at 512 push", irq, 1);
    rd_reg(RA_STAT, d); chk("R4 half clear at 512", d, 8'h00);
    pulse_tick();
    chk("R5 irq at 511 pop", irq, 1);
    rd_reg(RA_STAT, d); chk("R4 half set at 511", d, 8'h01);
    wr_reg(RA_HIEN, 8'h00);
    rd_reg(RA_HIEN, d); chk("R5 enable readback", d, 8'h00);
    flush_all();
    for (int i = 0; i < 512; i++) push(0, 8'(i));
    chk("R5 disabled push", irq, 0);
    pulse_tick();
    chk("R5 disabled pop", irq, 0);
    rd_reg(RA_STAT, d); chk("R4 half bit still tracks", d, 8'h01);
    wr_reg(RA_HIEN, 8'h03);
  endtask

  task automatic t_simul();
    logic [7:0] d;
    flush_all();
    for (int i = 0; i < 512; i++) push(0, 8'(i));
    rd_reg(RA_STAT, d);
    chk("R11 irq cleared", irq, 0);
    push_valid = 1; push_ch = 0; push_data = 8'hAA; tick = 1;
    @(negedge clk); push_valid = 0; tick = 0; #1;
    chk("R11 no irq", irq, 0);
    rd_reg(RA_STAT, d); chk("R11 count stays 512", d, 8'h00);
    pulse_tick();
    chk("R11 next pop hits 511", irq, 1);
    rd_reg(RA_STAT, d);
  endtask

  task automatic t_full();
    logic [7:0] d;
    int bad = 0;
    flush_all();
    for (int i = 0; i < 1022; i++) push(0, 8'(i));
    rd_reg(RA_STAT, d);
    chk("R6 no irq at 1022", irq, 0);
    push(0, 8'(1022));
    chk("R6 irq at 1023", irq, 1);
    rd_reg(RA_STAT, d); chk("R6 full bit", d, 8'h02);
    push_ch = 0; #1; chk("R10 ready before full", push_ready, 1);
    push(0, 8'(1023));
    push_ch = 0; #1; chk("R10 not ready", push_ready, 0);
    push(0, 8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      if (samp_out[7:0] !== 8'(i)) bad++;
      pulse_tick();
    end
    chk("R2 R10 order over 1024", bad, 0);
    chk("R3 drained silence", samp_out[7:0], 8'h80);
    push(0, 8'h77);
    chk("R2 wrap", samp_out[7:0], 8'h77);
    pulse_tick();
  endtask

  task automatic t_mode();
    logic [7:0] d;
    flush_all();
    push(0, 8'h99); push(0, 8'hAB); push(0, 8'hCD); push(1, 8'h55);
    pulse_tick();
    chk("R8 setup irq", irq, 1);
    wr_reg(RA_MODE, 8'h01);
    chk("R8 same mode keeps data", samp_out[7:0], 8'hAB);
    chk("R8 same mode keeps irq", irq, 1);
    wr_reg(RA_CTRL, 8'h7F);
    chk("R8 ctrl bit7 clear keeps", samp_out[7:0], 8'hAB);
    wr_reg(RA_MODE, 8'hFE);
    rd_reg(RA_MODE, d); chk("R8 mode masked", d, 8'h02);
    chk("R8 mode change flush", samp_out, 16'h8080);
    chk("R8 mode change irq", irq, 0);
    rd_reg(RA_STAT, d); chk("R8 status zero", d, 8'h00);
    wr_reg(RA_MODE, 8'h01);
    push(0, 8'h42);
    wr_reg(RA_CTRL, 8'h80);
    chk("R8 ctrl flush", samp_out[7:0], 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_direct();
    t_order();
    t_half();
    t_simul();
    t_full();
    t_mode();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule